// File: doc/BRIEF.md
# Power-Up Control Register Initializer

After reset, this block waits for a start request. It then steps through a fixed list of writes that puts a set of processor control registers into a known state. It issues one write per cycle on a shared strobe, select and data bus: the software interrupt summary, the interval-timer control, the memory-error register, the cache-disable register, the trap level, and the cache-disable register a second time. The cache-disable register is cleared twice because a diagnostic bit may power up set. While that bit is set, the first clear does not flush the cache; the second clear does.

The block holds instruction prefetch disabled for the whole run. It pulses a flush request with each cache-disable write and clears the highest-priority software interrupt request together with the timer write. It then blocks instruction decode for the cycles that follow that clear. The last step sends a one-cycle halt request to the console-entry logic, carrying the power-up halt code. After that the block stays finished until the next reset.

Top module: `pwrup_init_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy`, `reg_we`, `flush_req`, `hsir_clr`, `decode_inhibit`, `prefetch_dis` and `halt_req` are 0, and `halt_code` is 0.
- R2: While idle, the block starts nothing until `start` is seen high at a clock edge. The first write step appears in the cycle after that edge. `busy` is then high for exactly seven consecutive cycles.
- R3: The seven cycles of a run are, in order:
  - select 0 (software interrupt summary) with data 0;
  - select 1 (interval-timer control) with data 0;
  - select 2 (memory error) with data 0;
  - select 3 (cache disable) with data 0;
  - select 4 (trap level) with data `ASTLVL_INIT` (default 4);
  - select 3 with data 0;
  - a cycle with no write.

  In each write cycle `reg_we` is high. Whenever `reg_we` is low, `reg_sel` and `reg_wdata` are 0.
- R4: `hsir_clr` is high only in the interval-timer write cycle.
- R5: `flush_req` is high only in the two cache-disable write cycles, as two separate one-cycle pulses.
- R6: `decode_inhibit` is high for exactly `INHIBIT_CYCLES` (default 2) cycles that start right after the `hsir_clr` cycle. It is low at all other times.
- R7: `prefetch_dis` is high in every cycle in which `busy` is high and low otherwise.
- R8: `halt_req` is a one-cycle pulse in the seventh cycle, right after the second cache-disable write. In that cycle `halt_code` equals `HALT_CODE` (default 3); in every other cycle it is 0.
- R9: After the halt cycle, the block stays idle with all outputs at 0 and ignores `start` until reset.
- R10: `start` asserted during a run neither restarts nor alters the sequence.
- R11: A reset during a run abandons it at once. A later `start` runs the full sequence from the first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the initialization run |
| busy | output | 1 | Run in progress |
| reg_we | output | 1 | Control register write strobe |
| reg_sel | output | 3 | Register select (0 swint, 1 timer, 2 memerr, 3 cache disable, 4 trap level) |
| reg_wdata | output | DATA_W | Write data |
| hsir_clr | output | 1 | Clear highest-priority software interrupt request |
| flush_req | output | 1 | Cache flush request pulse |
| prefetch_dis | output | 1 | Instruction prefetch disable |
| decode_inhibit | output | 1 | Instruction decode blocked |
| halt_req | output | 1 | Console halt request pulse (done) |
| halt_code | output | 6 | Halt reason code |

## Verification
The hardest situations to reach from the ports are a reset that lands in the middle of a run and a `start` that arrives after the run has finished. Neither occurs in a plain power-up flow. The bench raises reset while the sequence is part-way through, then starts again and compares every cycle of the new run against the expected table. It also keeps `start` high both during a run and after it, and checks that neither the step order nor the idle state changes.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_SWINT    = 3'd0,
        SEL_TIMER    = 3'd1,
        SEL_MEMERR   = 3'd2,
        SEL_CACHECTL = 3'd3,
        SEL_TRAPLVL  = 3'd4
    } reg_sel_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SWINT,
        ST_TIMER,
        ST_MEMERR,
        ST_CACHE_A,
        ST_TRAPLVL,
        ST_CACHE_B,
        ST_HALT,
        ST_DONE
    } step_e;

    typedef struct packed {
        logic     we;
        reg_sel_e sel;
        logic     trap_val;
        logic     flush;
        logic     hsir_clr;
        logic     halt;
    } step_cmd_t;

    function automatic logic step_is_busy(input step_e s);
        return !(s == ST_IDLE || s == ST_DONE);
    endfunction

    function automatic step_e step_next(input step_e s, input logic start);
        case (s)
            ST_IDLE:    return start ? ST_SWINT : ST_IDLE;
            ST_SWINT:   return ST_TIMER;
            ST_TIMER:   return ST_MEMERR;
            ST_MEMERR:  return ST_CACHE_A;
            ST_CACHE_A: return ST_TRAPLVL;
            ST_TRAPLVL: return ST_CACHE_B;
            ST_CACHE_B: return ST_HALT;
            ST_HALT:    return ST_DONE;
            default:    return ST_DONE;
        endcase
    endfunction

endpackage

// File: rtl/pwrup_step_ctrl.sv
module pwrup_step_ctrl
    import pwrup_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output step_e step
);

    always_ff @(posedge clk) begin
        if (rst) step <= ST_IDLE;
        else     step <= step_next(step, start);
    end

    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (step == ST_IDLE && start) |=> (step == ST_SWINT)); // R2

    AST_DONE_STICKS: assert property (@(posedge clk) disable iff (rst)
        (step == ST_DONE) |=> (step == ST_DONE)); // R9

endmodule

// File: rtl/pwrup_step_decode.sv
module pwrup_step_decode
    import pwrup_pkg::*;
(
    input  step_e     step,
    output step_cmd_t cmd
);

    always_comb begin
        cmd = '0;
        case (step)
            ST_SWINT: begin
                cmd.we  = 1'b1;
                cmd.sel = SEL_SWINT;
            end
            ST_TIMER: begin
                cmd.we       = 1'b1;
                cmd.sel      = SEL_TIMER;
                cmd.hsir_clr = 1'b1;
            end
            ST_MEMERR: begin
                cmd.we  = 1'b1;
                cmd.sel = SEL_MEMERR;
            end
            ST_CACHE_A, ST_CACHE_B: begin
                cmd.we    = 1'b1;
                cmd.sel   = SEL_CACHECTL;
                cmd.flush = 1'b1;
            end
            ST_TRAPLVL: begin
                cmd.we       = 1'b1;
                cmd.sel      = SEL_TRAPLVL;
                cmd.trap_val = 1'b1;
            end
            ST_HALT: begin
                cmd.halt = 1'b1;
            end
            default: cmd = '0;
        endcase
    end

endmodule

// File: rtl/pwrup_decode_hold.sv
module pwrup_decode_hold #(
    parameter int HOLD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic inhibit
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (trigger)
            cnt <= CNT_W'(HOLD_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign inhibit = (cnt != '0);

    AST_HOLD_STARTS: assert property (@(posedge clk) disable iff (rst)
        trigger |=> inhibit); // R6

endmodule

// File: rtl/pwrup_init_seq.sv
module pwrup_init_seq
    import pwrup_pkg::*;
#(
    parameter int          DATA_W         = 32,
    parameter int          HALT_W         = 6,
    parameter int          INHIBIT_CYCLES = 2,
    parameter int          ASTLVL_INIT    = 4,
    parameter logic [5:0]  HALT_CODE      = 6'd3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    output logic                  busy,
    output logic                  reg_we,
    output logic [SEL_W-1:0]      reg_sel,
    output logic [DATA_W-1:0]     reg_wdata,
    output logic                  hsir_clr,
    output logic                  flush_req,
    output logic                  prefetch_dis,
    output logic                  decode_inhibit,
    output logic                  halt_req,
    output logic [HALT_W-1:0]     halt_code
);

    localparam logic [DATA_W-1:0] TRAP_WORD = DATA_W'(ASTLVL_INIT);
    localparam logic [HALT_W-1:0] CODE_WORD = HALT_W'(HALT_CODE);

    step_e     step;
    step_cmd_t cmd;

    pwrup_step_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .step  (step)
    );

    pwrup_step_decode u_decode (
        .step (step),
        .cmd  (cmd)
    );

    pwrup_decode_hold #(
        .HOLD_CYCLES (INHIBIT_CYCLES)
    ) u_hold (
        .clk     (clk),
        .rst     (rst),
        .trigger (cmd.hsir_clr),
        .inhibit (decode_inhibit)
    );

    assign busy         = step_is_busy(step);
    assign prefetch_dis = busy;
    assign reg_we       = cmd.we;
    assign reg_sel      = cmd.sel;
    assign reg_wdata    = cmd.trap_val ? TRAP_WORD : '0;
    assign hsir_clr     = cmd.hsir_clr;
    assign flush_req    = cmd.flush;
    assign halt_req     = cmd.halt;
    assign halt_code    = cmd.halt ? CODE_WORD : '0;

    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> busy); // R2

    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> !flush_req); // R5

    AST_FLUSH_ON_CACHE_WRITE: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> (reg_we && reg_sel == SEL_CACHECTL && reg_wdata == '0)); // R5

    AST_HALT_AFTER_FLUSH: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> $past(flush_req)); // R8

    AST_HALT_CODE_VALID: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> (halt_code == CODE_WORD && !reg_we)); // R8

    AST_INHIBIT_AFTER_HSIR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hsir_clr)) |-> decode_inhibit); // R6

    AST_HALT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        halt_req |=> (!halt_req && !busy)); // R9

endmodule

// File: tb/pwrup_init_seq_tb.sv
module pwrup_init_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    // {busy, we, sel[2:0], wdata[7:0], flush, hsir, inhib, pf, halt, code[5:0]}
    localparam logic [23:0] EXP_RUN [0:6] = '{
        {1'b1, 1'b1, 3'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0},
        {1'b1, 1'b1, 3'd1, 8'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'd0},
        {1'b1, 1'b1, 3'd2, 8'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd0},
        {1'b1, 1'b1, 3'd3, 8'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 6'd0},
        {1'b1, 1'b1, 3'd4, 8'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0},
        {1'b1, 1'b1, 3'd3, 8'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0},
        {1'b1, 1'b0, 3'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd3}
    };
    localparam logic [23:0] EXP_QUIET = 24'd0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          busy, reg_we, hsir_clr, flush_req, prefetch_dis;
    logic          decode_inhibit, halt_req;
    logic [2:0]    reg_sel;
    logic [DW-1:0] reg_wdata;
    logic [5:0]    halt_code;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrup_init_seq u_dut (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .busy           (busy),
        .reg_we         (reg_we),
        .reg_sel        (reg_sel),
        .reg_wdata      (reg_wdata),
        .hsir_clr       (hsir_clr),
        .flush_req      (flush_req),
        .prefetch_dis   (prefetch_dis),
        .decode_inhibit (decode_inhibit),
        .halt_req       (halt_req),
        .halt_code      (halt_code)
    );

    function automatic logic [23:0] observed();
        return {busy, reg_we, reg_sel, reg_wdata[7:0], flush_req, hsir_clr,
                decode_inhibit, prefetch_dis, halt_req, halt_code};
    endfunction

    task automatic check_vec(input logic [23:0] exp, input string tag);
        logic [23:0] act;
        act = observed();
        checks++;
        if (act !== exp || reg_wdata[DW-1:8] !== '0) begin
            errors++;
            $display("FAIL %s actual=%h wdata=%h expected=%h", tag, act, reg_wdata, exp);
        end
    endtask

    task automatic run_table(input string tag, input logic hold_start);
        for (int i = 0; i < 7; i++) begin
            start = hold_start;
            check_vec(EXP_RUN[i], $sformatf("%s step %0d", tag, i));
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_vec(EXP_QUIET, "R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        check_vec(EXP_QUIET, "R1 after reset");

        // R2: no run without start
        repeat (3) @(negedge clk);
        check_vec(EXP_QUIET, "R2 idle without start");

        // R2 R3 R4 R5 R6 R7 R8: table walk, start pulsed one cycle
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        run_table("R3 R4 R5 R6 R7 R8 run", 1'b0);

        // R9: finished, start ignored
        check_vec(EXP_QUIET, "R9 done");
        start = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check_vec(EXP_QUIET, "R9 start after done");
        end
        start = 1'b0;

        // R11: reset mid-run, then full run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_vec(EXP_RUN[0], "R11 partial step 0");
        @(negedge clk);
        check_vec(EXP_RUN[1], "R11 partial step 1");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_vec(EXP_QUIET, "R11 abandoned by reset");
        @(negedge clk);
        check_vec(EXP_QUIET, "R11 idle after reset");

        // R10: start held high for the whole run
        start = 1'b1;
        @(negedge clk);
        run_table("R10 R11 start held", 1'b1);
        start = 1'b0;
        check_vec(EXP_QUIET, "R10 R9 done after held start");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule